// File: doc/BRIEF.md
# Interrupt Controller Configuration Window

This block is the memory-mapped configuration front end of an I/O interrupt controller. Software reaches all of its internal state through two locations in a 256-byte region. The first holds a select pointer. The second is a data window onto whichever internal register the pointer names. The reachable registers are a 4-bit controller ID, a read-only version word, an arbitration ID, and a table of 24 routing entries. Each entry is 64 bits wide and is accessed as two independent 32-bit halves.

The region sits at a programmable base address and answers only while its enable flag is set. A configuration load port sets the base and the enable. Reads return data in the same cycle as a combinational function of the address and the stored state. Writes take effect at the clock edge. The whole routing table is presented on a flat output bus for the delivery engine.

Each entry holds these fields:
- vector in bits 7:0
- delivery mode in 10:8
- destination mode in 11
- delivery status in 12
- polarity in 13
- remote IRR in 14
- trigger mode in 15
- mask in 16
- destination ID in 63:56

The table stores entries raw. Only the mask bit has a defined reset value.

Top module: `irqw_top`

## Requirements
- R1: After reset the base is 0xFEC00000, decoding is enabled, the select register is 0, the ID and arbitration ID are 0, and every entry equals 0x0000_0000_0001_0000 (only the mask, bit 16, set). Entry i appears on `tbl_out[64*i+63:64*i]`.
- R2: `bus_hit` is high exactly when decoding is enabled and base <= `bus_addr` <= base + 0x100 (both ends inclusive). Within the region only `bus_addr[7:0]` is decoded: 0x00 is the select register and 0x10 is the data window.
- R3: The select register is 32 bits and reads back exactly as written. A claimed access at any offset other than 0x00 or 0x10 reads 0, and a write there changes nothing.
- R4: With select 0x01, the window reads 0x00170001: (pin count − 1) in bits 23:16 and the low nibble of version code 0x11 in bits 3:0. Writes to it are ignored.
- R5: With select 0x00 or 0x02, the window reads the ID in bits 27:24 with all other bits 0. A window write with select 0x00 stores data bits 27:24 as the ID. A window write with select 0x02 stores the full word on `arb_id` and leaves the ID unchanged.
- R6: With select s in 0x10..0x3F, the window addresses entry (s − 0x10) >> 1. An odd s selects bits 63:32 and an even s selects bits 31:0. A write replaces only that half of that entry, and a read returns that half.
- R7: A window access with any other select value (0x03..0x0F or >= 0x40) reads 0 and writes nothing. It drives `err_pulse` high for exactly the one cycle after the access edge.
- R8: A `cfg_load` cycle loads a new base and enable flag. While disabled, no address is claimed, reads return 0 and writes are ignored.
- R9: `bus_rdata` is 0 whenever `bus_rd` is low or the address is not claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Access address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_hit | output | 1 | Address falls in the enabled region |
| cfg_load | input | 1 | Load base and enable |
| cfg_base | input | 32 | New base address |
| cfg_enable | input | 1 | New enable flag |
| err_pulse | output | 1 | One-cycle flag for an undefined window target |
| ctl_id | output | 4 | Controller ID |
| arb_id | output | 32 | Arbitration ID word |
| tbl_out | output | 1536 | All routing entries, entry i at bits 64*i+63:64*i |

## Verification
The checker enforces several invariants on every cycle:
- Read data is idle-zero outside claimed reads.
- A claim never appears while decoding is disabled.
- The select register, the ID and the routing table stay frozen in any cycle that follows no write to them.
- Every error pulse traces back to a window access.

The directed scenarios show what only a reference model of the stored words can confirm: half-entry isolation, the index arithmetic at both ends of the table, the inclusive upper edge of the region, the version word, and that out-of-range selects leave every entry untouched.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

  typedef enum logic [2:0] {
    TGT_ID    = 3'd0,
    TGT_VER   = 3'd1,
    TGT_ARB   = 3'd2,
    TGT_ENTRY = 3'd3,
    TGT_BAD   = 3'd4
  } tgt_e;

  localparam logic [31:0] TABLE_FIRST_SEL = 32'h10;

  // Map a select value to the register the window reaches.
  function automatic tgt_e classify(input logic [31:0] sel, input int pins);
    logic [31:0] top_sel;
    top_sel = TABLE_FIRST_SEL + 32'(2 * pins);
    if (sel == 32'h0)                                return TGT_ID;
    else if (sel == 32'h1)                           return TGT_VER;
    else if (sel == 32'h2)                           return TGT_ARB;
    else if (sel >= TABLE_FIRST_SEL && sel < top_sel) return TGT_ENTRY;
    else                                             return TGT_BAD;
  endfunction

  // Entry number reached by a table select value.
  function automatic logic [31:0] entry_index(input logic [31:0] sel);
    logic [31:0] rel;
    rel = sel - TABLE_FIRST_SEL;
    return {1'b0, rel[31:1]};
  endfunction

  // Odd select values reach the upper half of an entry.
  function automatic logic upper_half(input logic [31:0] sel);
    return sel[0];
  endfunction

  // Read-only identification word.
  function automatic logic [31:0] version_word(input int pins, input logic [3:0] ver_lo);
    return {8'h00, 8'(pins - 1), 12'h000, ver_lo};
  endfunction

endpackage

// File: rtl/irqw_decode.sv
module irqw_decode #(
  parameter int ADDR_W       = 32,
  parameter int REGION_BYTES = 256,
  parameter int SEL_OFF      = 'h00,
  parameter int WIN_OFF      = 'h10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              en,
  output logic              hit,
  output logic              at_sel,
  output logic              at_win
);
  localparam int OFF_W = $clog2(REGION_BYTES);

  logic [ADDR_W:0] a_x, lo_x, hi_x;
  logic [OFF_W-1:0] off;

  always_comb begin
    a_x  = {1'b0, addr};
    lo_x = {1'b0, base};
    hi_x = lo_x + (ADDR_W+1)'(REGION_BYTES);
    hit  = en && (a_x >= lo_x) && (a_x <= hi_x);
    off  = addr[OFF_W-1:0];
    at_sel = (off == OFF_W'(SEL_OFF));
    at_win = (off == OFF_W'(WIN_OFF));
  end
endmodule

// File: rtl/irqw_regs.sv
module irqw_regs #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          ID_W     = 4,
  parameter int          ID_LSB   = 24,
  parameter logic [31:0] BASE_RST = 32'hFEC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic              id_we,
  input  logic              arb_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_enable,
  output logic [DATA_W-1:0] sel_q,
  output logic [ID_W-1:0]   id_q,
  output logic [DATA_W-1:0] arb_q,
  output logic [ADDR_W-1:0] base_q,
  output logic              en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      id_q   <= '0;
      arb_q  <= '0;
      base_q <= ADDR_W'(BASE_RST);
      en_q   <= 1'b1;
    end else begin
      if (sel_we) sel_q <= wdata;
      if (id_we)  id_q  <= wdata[ID_LSB +: ID_W];
      if (arb_we) arb_q <= wdata;
      if (cfg_load) begin
        base_q <= cfg_base;
        en_q   <= cfg_enable;
      end
    end
  end
endmodule

// File: rtl/irqw_table.sv
module irqw_table #(
  parameter int PINS     = 24,
  parameter int DATA_W   = 32,
  parameter int MASK_BIT = 16,
  parameter int IDX_W    = $clog2(PINS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic                       hi_half,
  input  logic [DATA_W-1:0]          wdata,
  output logic [PINS*2*DATA_W-1:0]   flat
);
  localparam int ENTRY_W = 2 * DATA_W;
  localparam logic [ENTRY_W-1:0] RST_ENTRY = ENTRY_W'(1) << MASK_BIT;

  logic [ENTRY_W-1:0] ent [PINS];

  for (genvar g = 0; g < PINS; g++) begin : g_entry
    logic hit_me;
    assign hit_me = we && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent[g] <= RST_ENTRY;
      end else if (hit_me) begin
        if (hi_half) ent[g][ENTRY_W-1:DATA_W] <= wdata;
        else         ent[g][DATA_W-1:0]       <= wdata;
      end
    end

    assign flat[g*ENTRY_W +: ENTRY_W] = ent[g];
  end
endmodule

// File: rtl/irqw_top.sv
module irqw_top
  import irqw_pkg::*;
#(
  parameter int          PINS         = 24,
  parameter int          ADDR_W       = 32,
  parameter int          DATA_W       = 32,
  parameter int          ID_W         = 4,
  parameter int          ID_LSB       = 24,
  parameter int          REGION_BYTES = 256,
  parameter logic [7:0]  VERSION_CODE = 8'h11,
  parameter logic [31:0] BASE_RST     = 32'hFEC0_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_hit,
  input  logic                     cfg_load,
  input  logic [ADDR_W-1:0]        cfg_base,
  input  logic                     cfg_enable,
  output logic                     err_pulse,
  output logic [ID_W-1:0]          ctl_id,
  output logic [DATA_W-1:0]        arb_id,
  output logic [PINS*2*DATA_W-1:0] tbl_out
);
  localparam int ENTRY_W = 2 * DATA_W;
  localparam int IDX_W   = $clog2(PINS);

  // Named internal events, also observed by the checker.
  logic              at_sel, at_win;
  logic              sel_we, win_we, win_acc;
  logic              region_en;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] sel_q;
  tgt_e              tgt;
  logic [IDX_W-1:0]  idx;
  logic              hi_half;
  logic [ENTRY_W-1:0] cur_entry;
  logic              err_q;

  irqw_decode #(
    .ADDR_W(ADDR_W), .REGION_BYTES(REGION_BYTES), .SEL_OFF('h00), .WIN_OFF('h10)
  ) u_dec (
    .addr(bus_addr), .base(base_q), .en(region_en),
    .hit(bus_hit), .at_sel(at_sel), .at_win(at_win)
  );

  always_comb begin
    tgt     = classify(sel_q, PINS);
    idx     = IDX_W'(entry_index(sel_q));
    hi_half = upper_half(sel_q);
    sel_we  = bus_wr && bus_hit && at_sel;
    win_we  = bus_wr && bus_hit && at_win;
    win_acc = (bus_wr || bus_rd) && bus_hit && at_win;
  end

  irqw_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .ID_LSB(ID_LSB), .BASE_RST(BASE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sel_we(sel_we),
    .id_we(win_we && (tgt == TGT_ID)),
    .arb_we(win_we && (tgt == TGT_ARB)),
    .wdata(bus_wdata),
    .cfg_load(cfg_load), .cfg_base(cfg_base), .cfg_enable(cfg_enable),
    .sel_q(sel_q), .id_q(ctl_id), .arb_q(arb_id),
    .base_q(base_q), .en_q(region_en)
  );

  irqw_table #(
    .PINS(PINS), .DATA_W(DATA_W), .MASK_BIT(16), .IDX_W(IDX_W)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(win_we && (tgt == TGT_ENTRY)),
    .idx(idx), .hi_half(hi_half), .wdata(bus_wdata),
    .flat(tbl_out)
  );

  assign cur_entry = tbl_out[idx*ENTRY_W +: ENTRY_W];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && bus_hit) begin
      if (at_sel) begin
        bus_rdata = sel_q;
      end else if (at_win) begin
        unique case (tgt)
          TGT_ID, TGT_ARB: bus_rdata = DATA_W'(ctl_id) << ID_LSB;
          TGT_VER:         bus_rdata = version_word(PINS, VERSION_CODE[3:0]);
          TGT_ENTRY:       bus_rdata = hi_half ? cur_entry[ENTRY_W-1:DATA_W]
                                               : cur_entry[DATA_W-1:0];
          default:         bus_rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= win_acc && (tgt == TGT_BAD);
  end
  assign err_pulse = err_q;

endmodule

// File: rtl/irqw_checker.sv
module irqw_checker #(
  parameter int PINS   = 24,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_rd,
  input logic                     bus_hit,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     err_pulse,
  input logic                     region_en,
  input logic                     win_we,
  input logic                     win_acc,
  input logic                     sel_we,
  input logic [DATA_W-1:0]        sel_q,
  input logic [ID_W-1:0]          ctl_id,
  input logic [PINS*2*DATA_W-1:0] tbl_out
);
  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_hit) |-> bus_rdata == '0);

  assert_claim_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |-> region_en);

  assert_err_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(win_acc));

  assert_err_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !win_acc) |=> !err_pulse);

  assert_table_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_we) |-> $stable(tbl_out));

  assert_select_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel_we) |-> $stable(sel_q));

  assert_id_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_we) |-> $stable(ctl_id));
endmodule

bind irqw_top irqw_checker #(.PINS(PINS), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_hit(bus_hit),
  .bus_rdata(bus_rdata), .err_pulse(err_pulse), .region_en(region_en),
  .win_we(win_we), .win_acc(win_acc), .sel_we(sel_we), .sel_q(sel_q),
  .ctl_id(ctl_id), .tbl_out(tbl_out)
);

// File: tb/sim_irqw_top.sv
module sim_irqw_top;
  localparam int PINS = 24;
  localparam logic [31:0] BASE0 = 32'hFEC0_0000;
  localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, cfg_base = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, cfg_load = 1'b0, cfg_enable = 1'b0;
  logic [31:0] bus_rdata, arb_id;
  logic bus_hit, err_pulse;
  logic [3:0] ctl_id;
  logic [PINS*64-1:0] tbl_out;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_tbl [PINS];

  always #10 clk = ~clk;

  irqw_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
    .cfg_load(cfg_load), .cfg_base(cfg_base), .cfg_enable(cfg_enable),
    .err_pulse(err_pulse), .ctl_id(ctl_id), .arb_id(arb_id), .tbl_out(tbl_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < PINS; i++) check(req, tbl_out[i*64 +: 64], exp_tbl[i]);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #2; d = bus_rdata;
    @(posedge clk); #1; bus_rd = 1'b0;
  endtask

  task automatic probe_hit(input logic [31:0] a, output logic h);
    @(negedge clk); bus_addr = a; #2; h = bus_hit;
  endtask

  task automatic do_cfg(input logic [31:0] b, input logic e);
    @(negedge clk); cfg_base = b; cfg_enable = e; cfg_load = 1'b1;
    @(posedge clk); #1; cfg_load = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic h;
    check_table("R1 reset entries");
    check("R1 reset id", 64'(ctl_id), 64'h0);
    check("R1 reset arb", 64'(arb_id), 64'h0);
    probe_hit(BASE0, h);
    check("R1 reset base/enable", 64'(h), 64'h1);
    do_read(BASE0, d);
    check("R1 reset select", 64'(d), 64'h0);
    check("R9 idle rdata", 64'(bus_rdata), 64'h0);
  endtask

  task automatic t_select;
    logic [31:0] d;
    do_write(BASE0, 32'hA5A5_1234);
    do_read(BASE0, d);
    check("R3 select readback", 64'(d), 64'hA5A5_1234);
    do_write(BASE0 + 32'h04, 32'hFFFF_FFFF);
    do_read(BASE0 + 32'h04, d);
    check("R3 other offset reads 0", 64'(d), 64'h0);
    do_read(BASE0, d);
    check("R3 other offset write ignored", 64'(d), 64'hA5A5_1234);
    check_table("R3 table untouched");
  endtask

  task automatic t_version;
    logic [31:0] d;
    do_write(BASE0, 32'h1);
    do_read(BASE0 + 32'h10, d);
    check("R4 version word", 64'(d), 64'h0017_0001);
    do_write(BASE0 + 32'h10, 32'hFFFF_FFFF);
    do_read(BASE0 + 32'h10, d);
    check("R4 version write ignored", 64'(d), 64'h0017_0001);
    check_table("R4 table untouched");
  endtask

  task automatic t_ids;
    logic [31:0] d;
    do_write(BASE0, 32'h0);
    do_write(BASE0 + 32'h10, 32'hF765_4321);
    check("R5 id stored", 64'(ctl_id), 64'h7);
    do_read(BASE0 + 32'h10, d);
    check("R5 id read sel 0", 64'(d), 64'h0700_0000);
    do_write(BASE0, 32'h2);
    do_read(BASE0 + 32'h10, d);
    check("R5 id read sel 2", 64'(d), 64'h0700_0000);
    do_write(BASE0 + 32'h10, 32'hDEAD_BEEF);
    check("R5 arb stored", 64'(arb_id), 64'hDEAD_BEEF);
    check("R5 id unchanged by arb write", 64'(ctl_id), 64'h7);
  endtask

  task automatic t_entries;
    logic [31:0] d;
    do_write(BASE0, 32'h1A);
    do_write(BASE0 + 32'h10, 32'h0000_A031);
    exp_tbl[5][31:0] = 32'h0000_A031;
    check_table("R6 low half entry 5");
    do_write(BASE0, 32'h1B);
    do_write(BASE0 + 32'h10, 32'h0F00_0000);
    exp_tbl[5][63:32] = 32'h0F00_0000;
    check_table("R6 high half entry 5");
    do_read(BASE0 + 32'h10, d);
    check("R6 read high half", 64'(d), 64'h0F00_0000);
    do_write(BASE0, 32'h1A);
    do_read(BASE0 + 32'h10, d);
    check("R6 read low half", 64'(d), 64'h0000_A031);
    do_write(BASE0, 32'h3F);
    do_write(BASE0 + 32'h10, 32'h1234_5678);
    exp_tbl[23][63:32] = 32'h1234_5678;
    do_write(BASE0, 32'h10);
    do_write(BASE0 + 32'h10, 32'h0000_00FE);
    exp_tbl[0][31:0] = 32'h0000_00FE;
    check_table("R6 first and last entry");
  endtask

  task automatic t_bad_sel;
    logic [31:0] d;
    do_write(BASE0, 32'h40);
    do_write(BASE0 + 32'h10, 32'hFFFF_FFFF);
    check("R7 err after bad write", 64'(err_pulse), 64'h1);
    @(posedge clk); #1;
    check("R7 err one cycle", 64'(err_pulse), 64'h0);
    check_table("R7 bad write ignored");
    do_write(BASE0, 32'h05);
    do_read(BASE0 + 32'h10, d);
    check("R7 err after bad read", 64'(err_pulse), 64'h1);
    check("R7 bad read 0", 64'(d), 64'h0);
    do_write(BASE0, 32'h3F);
    check("R7 no err on good select", 64'(err_pulse), 64'h0);
  endtask

  task automatic t_region;
    logic h;
    logic [31:0] d;
    probe_hit(BASE0 + 32'h100, h);
    check("R2 inclusive top hit", 64'(h), 64'h1);
    probe_hit(BASE0 + 32'h101, h);
    check("R2 above top miss", 64'(h), 64'h0);
    probe_hit(BASE0 - 32'h1, h);
    check("R2 below base miss", 64'(h), 64'h0);
    do_read(BASE0 + 32'h100, d);
    check("R2 top aliases select", 64'(d), 64'h3F);
    do_read(BASE0 + 32'h80, d);
    check("R2 unused offset reads 0", 64'(d), 64'h0);
    do_read(BASE0 - 32'h10, d);
    check("R9 unclaimed read 0", 64'(d), 64'h0);
  endtask

  task automatic t_cfg;
    logic h;
    logic [31:0] d;
    do_cfg(32'h1000_0000, 1'b1);
    probe_hit(BASE0, h);
    check("R8 old base released", 64'(h), 64'h0);
    do_read(32'h1000_0000, d);
    check("R8 new base select", 64'(d), 64'h3F);
    do_cfg(32'h1000_0000, 1'b0);
    probe_hit(32'h1000_0000, h);
    check("R8 disabled no hit", 64'(h), 64'h0);
    do_write(32'h1000_0000, 32'h77);
    do_read(32'h1000_0000, d);
    check("R8 disabled read 0", 64'(d), 64'h0);
    do_cfg(32'h1000_0000, 1'b1);
    do_read(32'h1000_0000, d);
    check("R8 disabled write ignored", 64'(d), 64'h3F);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < PINS; i++) exp_tbl[i] = ENT_RST;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_select;
    t_version;
    t_ids;
    t_entries;
    t_bad_sel;
    t_region;
    t_cfg;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule